// File: doc/BRIEF.md
# Temperature-Scaled Self-Discharge Counter

This block estimates battery self-discharge by keeping a 16-bit counter that advances at a rate set by die temperature. A slow timebase supplies one tick per interval (128 ticks per hour by default). A prescaler divides those ticks by a power of two, and the temperature band selects that power. The block updates its count from two things: the tick input and an 11-bit die temperature code in quarter-kelvin steps.

The nominal band runs from 288 K up to, but not including, 308 K. In that band the counter advances once per hour. Each 10 K step above the nominal band doubles the rate, and the rate stops rising at 16 counts per hour. Each 10 K step below the nominal band halves the rate, and the rate stops falling at one count per 8 hours. The host clears the count with a single-cycle request. The count wraps freely and never saturates. The host reads it as a high byte and a low byte. The block has no mode gating, so counting goes on through every power state as long as ticks arrive.

Top module: `selfdis_counter`

## Requirements
- R1: After reset the count is zero and the prescaler is at its start. The first period uses the nominal division of 2^BASE_LOG2 ticks, whatever the temperature.
- R2: For a temperature code from 4·288 (1152) up to 4·308−1 (1231), the period between increments is 2^BASE_LOG2 ticks (128 by default).
- R3: For a code ≥ 4·(298+10n) with n = 1..4 (thresholds 1232, 1272, 1312, 1352), the period is 2^(BASE_LOG2−n) ticks. Codes above 1352 keep the n = 4 period (16 counts per hour by default).
- R4: For a code < 4·(298−10n) with n = 1..3 (thresholds 1152, 1112, 1072), the period is 2^(BASE_LOG2+n) ticks. Colder codes keep the n = 3 period (one count per 8 hours by default).
- R5: The band is sampled only on the tick that ends a period. A temperature change in the middle of a period leaves that period's length unchanged, and the next period uses the temperature present at that ending tick.
- R6: An increment from 0xFFFF gives 0x0000, and no flag is raised.
- R7: When the clear input is high at a clock edge, the count is zero after that edge, even if an increment was due at the same edge. The prescaler phase is not changed.
- R8: The count changes only by +1 on the tick that ends a period, or to zero on a clear. With no tick and no clear it holds.
- R9: count_hi_o carries count bits 15:8 and count_lo_o carries bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| temp_i | input | 11 | Die temperature, 0.25 K per LSB |
| clr_i | input | 1 | Synchronous clear of the count |
| count_hi_o | output | 8 | Count high byte |
| count_lo_o | output | 8 | Count low byte |

## Verification
The count is registered once. An increment or a clear is therefore visible one clock after the edge that carried the tick or the clear. The bench drives each tick for one cycle starting at a falling edge and reads the count at the next falling edge. A band change only takes effect on the period after the one in progress. For that reason, each rate measurement first runs ticks until the count moves, which completes the period already under way. It then counts the ticks to the next change, and that second figure must equal the period the requirement gives for the temperature code.

// File: rtl/selfdis_pkg.sv
package selfdis_pkg;
  function automatic int unsigned kelvin_to_code(input int unsigned kelvin,
                                                 input int unsigned lsb_per_k);
    return kelvin * lsb_per_k;
  endfunction
endpackage

// File: rtl/selfdis_band_sel.sv
module selfdis_band_sel #(
  parameter int unsigned TEMP_W    = 11,
  parameter int unsigned LSB_PER_K = 4,
  parameter int unsigned NOM_K     = 298,
  parameter int unsigned BAND_K    = 10,
  parameter int unsigned UP_STEPS  = 4,
  parameter int unsigned DN_STEPS  = 3,
  parameter int unsigned BASE_LOG2 = 7,
  parameter int unsigned SH_W      = 4
) (
  input  logic [TEMP_W-1:0] temp_i,
  output logic [SH_W-1:0]   shift_o
);
  import selfdis_pkg::*;

  logic [UP_STEPS-1:0] hot;
  logic [DN_STEPS-1:0] cold;

  for (genvar g = 0; g < UP_STEPS; g++) begin : g_hot
    localparam int unsigned TH = kelvin_to_code(NOM_K + BAND_K * (g + 1), LSB_PER_K);
    assign hot[g] = temp_i >= TEMP_W'(TH);
  end

  for (genvar g = 0; g < DN_STEPS; g++) begin : g_cold
    localparam int unsigned TH = kelvin_to_code(NOM_K - BAND_K * (g + 1), LSB_PER_K);
    assign cold[g] = temp_i < TEMP_W'(TH);
  end

  // thresholds are monotonic, so the count of crossed edges is the band index
  always_comb begin
    shift_o = SH_W'(int'(BASE_LOG2) + $countones(cold) - $countones(hot));
  end
endmodule

// File: rtl/selfdis_prescaler.sv
module selfdis_prescaler #(
  parameter int unsigned BASE_LOG2 = 7,
  parameter int unsigned PRE_W     = 10,
  parameter int unsigned SH_W      = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [SH_W-1:0] shift_next_i,
  output logic [SH_W-1:0] shift_o,
  output logic            wrap_o
);
  logic [PRE_W-1:0] pre_q;
  logic [SH_W-1:0]  shift_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;

  assign span    = (PRE_W + 1)'(1) << shift_q;
  assign last    = PRE_W'(span - 1'b1);
  assign wrap_o  = tick_i && (pre_q == last);
  assign shift_o = shift_q;

  // band latched only at period end: division and phase stay consistent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      shift_q <= SH_W'(BASE_LOG2);
    end else if (tick_i) begin
      if (wrap_o) begin
        pre_q   <= '0;
        shift_q <= shift_next_i;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/selfdis_accum.sv
module selfdis_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (clr_i)  count_o <= '0;
    else if (inc_i)  count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/selfdis_counter.sv
module selfdis_counter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TEMP_W    = 11,
  parameter int unsigned LSB_PER_K = 4,
  parameter int unsigned NOM_K     = 298,
  parameter int unsigned BAND_K    = 10,
  parameter int unsigned UP_STEPS  = 4,
  parameter int unsigned DN_STEPS  = 3,
  parameter int unsigned BASE_LOG2 = 7,
  localparam int unsigned HI_W     = CNT_W - CNT_W / 2,
  localparam int unsigned LO_W     = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              clr_i,
  output logic [HI_W-1:0]   count_hi_o,
  output logic [LO_W-1:0]   count_lo_o
);
  localparam int unsigned PRE_W = BASE_LOG2 + DN_STEPS;
  localparam int unsigned SH_W  = $clog2(PRE_W + 1);

  logic [SH_W-1:0]  shift_next_w;
  logic [SH_W-1:0]  shift_q_w;
  logic             wrap_w;
  logic [CNT_W-1:0] count_w;

  selfdis_band_sel #(
    .TEMP_W(TEMP_W), .LSB_PER_K(LSB_PER_K), .NOM_K(NOM_K), .BAND_K(BAND_K),
    .UP_STEPS(UP_STEPS), .DN_STEPS(DN_STEPS), .BASE_LOG2(BASE_LOG2), .SH_W(SH_W)
  ) i_band_sel (
    .temp_i (temp_i),
    .shift_o(shift_next_w)
  );

  selfdis_prescaler #(
    .BASE_LOG2(BASE_LOG2), .PRE_W(PRE_W), .SH_W(SH_W)
  ) i_prescaler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .shift_next_i(shift_next_w),
    .shift_o     (shift_q_w),
    .wrap_o      (wrap_w)
  );

  selfdis_accum #(.CNT_W(CNT_W)) i_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (wrap_w),
    .clr_i  (clr_i),
    .count_o(count_w)
  );

  assign count_hi_o = count_w[CNT_W-1:LO_W];
  assign count_lo_o = count_w[LO_W-1:0];
endmodule

// File: rtl/selfdis_counter_chk.sv
module selfdis_counter_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SH_W      = 4,
  parameter int unsigned BASE_LOG2 = 7,
  parameter int unsigned UP_STEPS  = 4,
  parameter int unsigned DN_STEPS  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             wrap_i,
  input logic [SH_W-1:0]  shift_i,
  input logic [CNT_W-1:0] count_i
);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_i == '0);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wrap_i) |=> $stable(count_i));

  assert_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wrap_i) |=> count_i == CNT_W'($past(count_i) + 1'b1));

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && wrap_i && count_i == '1) |=> count_i == '0);

  assert_band_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(shift_i));

  // R3 and R4 clamps bound the division exponent
  assert_shift_range_R3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i >= SH_W'(BASE_LOG2 - UP_STEPS)) && (shift_i <= SH_W'(BASE_LOG2 + DN_STEPS)));
endmodule

bind selfdis_counter selfdis_counter_chk #(
  .CNT_W(CNT_W), .SH_W(SH_W), .BASE_LOG2(BASE_LOG2),
  .UP_STEPS(UP_STEPS), .DN_STEPS(DN_STEPS)
) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .wrap_i (wrap_w),
  .shift_i(shift_q_w),
  .count_i(count_w)
);

// File: tb/test_selfdis_counter.sv
module test_selfdis_counter;
  localparam int BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        clr = 1'b0;
  logic [10:0] temp = 11'd1200;
  logic [7:0]  hi, lo;
  wire  [15:0] cnt = {hi, lo};

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  selfdis_counter #(.BASE_LOG2(BASE)) i_selfdis_counter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .temp_i(temp), .clr_i(clr),
    .count_hi_o(hi), .count_lo_o(lo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_period(input int t);
    int e = 0;
    for (int n = 1; n <= 4; n++) if (t >= (298 + 10 * n) * 4) e++;
    for (int n = 1; n <= 3; n++) if (t < (298 - 10 * n) * 4) e--;
    return 1 << (BASE - e);
  endfunction

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks_to_change(output int n);
    logic [15:0] p = cnt;
    n = 0;
    do begin
      do_tick();
      n++;
    end while (cnt == p && n < 5000);
  endtask

  task automatic measure(input int t, input string req);
    int n;
    temp = 11'(t);
    ticks_to_change(n);
    ticks_to_change(n);
    chk(n == exp_period(t), req, n, exp_period(t));
  endtask

  initial begin
    #1900us;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt == 16'd0, "R1 reset count", cnt, 0);

    // R1: first period nominal even when hot
    temp = 11'd2047;
    ticks_to_change(n);
    chk(n == (1 << BASE), "R1 first period", n, 1 << BASE);
    ticks_to_change(n);
    chk(n == 1, "R3 hot after first wrap", n, 1);

    // R2 R3 R4 sweep, with every band edge on both sides
    for (int t = 1040; t <= 1380; t += 4) begin
      if (t >= 1152 && t < 1232) measure(t, "R2 nominal sweep");
      else if (t >= 1232)        measure(t, "R3 hot sweep");
      else                       measure(t, "R4 cold sweep");
    end
    measure(1151, "R4 edge 1151");
    measure(1152, "R2 edge 1152");
    measure(1231, "R2 edge 1231");
    measure(1232, "R3 edge 1232");
    measure(1271, "R3 edge 1271");
    measure(1272, "R3 edge 1272");
    measure(1311, "R3 edge 1311");
    measure(1312, "R3 edge 1312");
    measure(1351, "R3 edge 1351");
    measure(1352, "R3 edge 1352");
    measure(2047, "R3 clamp top");
    measure(1111, "R4 edge 1111");
    measure(1112, "R4 edge 1112");
    measure(1071, "R4 edge 1071");
    measure(1072, "R4 edge 1072");
    measure(0,    "R4 clamp bottom");

    // R5: mid-period change does not alter the running period
    temp = 11'd1200;
    ticks_to_change(n);
    repeat (5) do_tick();
    temp = 11'd2047;
    ticks_to_change(n);
    chk(n == 11, "R5 period kept", n, 11);
    ticks_to_change(n);
    chk(n == 1, "R5 new band next", n, 1);

    // R7: clear mid-period, prescaler phase kept
    temp = 11'd1200;
    ticks_to_change(n);
    ticks_to_change(n);
    repeat (3) do_tick();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(cnt == 16'd0, "R7 clear", cnt, 0);
    ticks_to_change(n);
    chk(n == 13, "R7 phase kept", n, 13);
    chk(cnt == 16'd1, "R7 count after clear", cnt, 1);
    // R7: clear wins over coincident increment
    repeat (15) do_tick();
    clr = 1'b1;
    do_tick();
    clr = 1'b0;
    chk(cnt == 16'd0, "R7 clear beats increment", cnt, 0);
    ticks_to_change(n);
    chk(n == 16, "R7 next period", n, 16);

    // R8: no tick, no change
    p = cnt;
    repeat (50) @(negedge clk);
    chk(cnt == p, "R8 hold without tick", cnt, p);

    // R9: byte split
    temp = 11'd2047;
    ticks_to_change(n);
    ticks_to_change(n);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (300) do_tick();
    chk(hi == 8'h01, "R9 high byte", hi, 8'h01);
    chk(lo == 8'h2C, "R9 low byte", lo, 8'h2C);

    // R6: wrap past all ones
    while (cnt != 16'hFFFF) do_tick();
    chk(hi == 8'hFF && lo == 8'hFF, "R6 reach max", cnt, 16'hFFFF);
    do_tick();
    chk(cnt == 16'd0, "R6 wrap to zero", cnt, 0);
    do_tick();
    chk(cnt == 16'd1, "R6 counts on", cnt, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule